// File: doc/BRIEF.md
# Big-Endian Load/Store Byte Aligner

This block sits between the register file path (integer and floating-point, 64 bits wide) and a byte-addressable data memory port that is 64 bits wide. Memory is organised big-endian: the most significant byte of any multi-byte item is stored at the lowest byte address. The effective address is computed elsewhere. Only its three low bits reach this block, together with an access size, a signed/unsigned flag and a load/store select.

For a store, the block moves the right-justified register value onto the memory byte lanes the access covers, in big-endian order. It raises a write enable for exactly those lanes. For a load, it picks the addressed bytes out of the memory word and right-justifies them in the register value. It then sign-extends or zero-extends the result.

Every access size must be naturally aligned. A misaligned access raises an error flag and is suppressed. Single-precision floating-point transfers use the word size code, and double-precision transfers use the double-word code. The block is purely combinational.

Top module: `be_aligner`

## Requirements
- R1: `misalign` is 1 exactly when `addr_lo` is not a multiple of the access size. The size codes are 00 = 1 byte, 01 = 2 bytes, 10 = 4 bytes and 11 = 8 bytes, so a byte access is never misaligned.
- R2: Byte lane k (k = 0..7) is `mem_wdata[63-8k:56-8k]` and holds address offset k. On an aligned store of N bytes, lane `addr_lo` carries the most significant byte of `st_data[8N-1:0]`. Lane `addr_lo`+N-1 carries its least significant byte, and the lanes between carry the bytes between, in order.
- R3: On an aligned store, `mem_be[i]` enables `mem_wdata[8i+7:8i]`. Exactly the N lanes from `addr_lo` to `addr_lo`+N-1 are enabled.
- R4: A misaligned access drives `mem_be` to all zeros and `ld_data` to zero.
- R5: On an aligned load of N bytes, `ld_data[8N-1:0]` holds the memory bytes at offsets `addr_lo`..`addr_lo`+N-1. The byte at `addr_lo` is the most significant of these.
- R6: On an aligned load shorter than 8 bytes, bits above 8N copy bit 8N-1 when `is_signed` is 1 and are 0 when `is_signed` is 0. A double-word load is returned unchanged.
- R7: When `is_store` is 0, `mem_be` is all zeros. When `is_store` is 1, `ld_data` is zero.
- R8: The results depend only on the current inputs. They are valid in the same cycle the inputs are applied, with no state held between accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_lo | input | 3 | Low bits of the effective address (byte offset within the memory word) |
| size | input | 2 | Access size code: 00 byte, 01 half word, 10 word, 11 double word |
| is_signed | input | 1 | Load result is sign-extended when 1, zero-extended when 0 |
| is_store | input | 1 | 1 selects a store, 0 a load |
| st_data | input | 64 | Right-justified register value to store |
| mem_rdata | input | 64 | Memory word read from the aligned 8-byte location |
| mem_wdata | output | 64 | Store data placed on the memory byte lanes |
| mem_be | output | 8 | Per-lane byte write enables, bit i for bits 8i+7:8i |
| ld_data | output | 64 | Aligned and extended load result |
| misalign | output | 1 | Access address is not a multiple of its size |

## Verification
There are no registers in the block, so every output is due in the cycle its inputs are applied (zero cycles of latency). The bench applies each stimulus just after a rising clock edge. It samples all outputs at the following falling edge, half a period later, when the combinational paths have settled and no other process is driving inputs. Expected lane placement, enables and extended load values come from bench functions that walk the bytes one at a time. They are compared across directed corner cases (end lanes, sign boundaries, misaligned offsets for each size) and several thousand seeded random accesses.

// File: rtl/be_align_pkg.sv
package be_align_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_DBL  = 2'b11
  } acc_size_e;

endpackage

// File: rtl/be_misalign_det.sv
module be_misalign_det
  import be_align_pkg::*;
#(
  parameter int OFS_W = 3
) (
  input  logic [OFS_W-1:0] ofs,
  input  acc_size_e        size,
  output logic             misalign
);

  logic [OFS_W-1:0] low_mask;

  // Bits below log2(size) must be zero for a natural alignment.
  always_comb begin
    low_mask = '0;
    for (int b = 0; b < OFS_W; b++) begin
      if (b < int'(size)) low_mask[b] = 1'b1;
    end
    misalign = |(ofs & low_mask);
  end

endmodule

// File: rtl/be_store_place.sv
module be_store_place
  import be_align_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LANES  = DATA_W / 8,
  parameter int OFS_W  = $clog2(LANES)
) (
  input  logic [OFS_W-1:0]  ofs,
  input  acc_size_e         size,
  input  logic              wr_ok,
  input  logic [DATA_W-1:0] st_data,
  output logic [DATA_W-1:0] wdata,
  output logic [LANES-1:0]  be
);

  int nbytes;
  logic [DATA_W-1:0] top_just;

  // Move the item to the top of the word, then down to its first lane.
  always_comb begin
    nbytes   = 1 << int'(size);
    top_just = st_data << (8 * (LANES - nbytes));
    wdata    = top_just >> (8 * int'(ofs));
  end

  // Lane k sits at bits [DATA_W-1-8k -: 8], enabled by be[LANES-1-k].
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign be[LANES-1-k] = wr_ok && (k >= int'(ofs)) && (k < int'(ofs) + nbytes);
  end

endmodule

// File: rtl/be_load_extract.sv
module be_load_extract
  import be_align_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LANES  = DATA_W / 8,
  parameter int OFS_W  = $clog2(LANES)
) (
  input  logic [OFS_W-1:0]  ofs,
  input  acc_size_e         size,
  input  logic              is_signed,
  input  logic              rd_ok,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] ld_data
);

  int nbytes;
  logic [DATA_W-1:0] first_top;
  logic [DATA_W-1:0] just;
  logic [DATA_W-1:0] keep_mask;
  logic              msb;

  always_comb begin
    nbytes    = 1 << int'(size);
    first_top = mem_rdata << (8 * int'(ofs));
    just      = first_top >> (8 * (LANES - nbytes));
    keep_mask = {DATA_W{1'b1}} >> (8 * (LANES - nbytes));
    msb       = first_top[DATA_W-1];
    if (!rd_ok) begin
      ld_data = '0;
    end else if (is_signed && msb) begin
      ld_data = just | ~keep_mask;
    end else begin
      ld_data = just;
    end
  end

endmodule

// File: rtl/be_aligner.sv
module be_aligner
  import be_align_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LANES  = DATA_W / 8,
  parameter int OFS_W  = $clog2(LANES)
) (
  input  logic [OFS_W-1:0]  addr_lo,
  input  logic [1:0]        size,
  input  logic              is_signed,
  input  logic              is_store,
  input  logic [DATA_W-1:0] st_data,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [LANES-1:0]  mem_be,
  output logic [DATA_W-1:0] ld_data,
  output logic              misalign
);

  acc_size_e size_e;
  logic      wr_ok;
  logic      rd_ok;

  assign size_e = acc_size_e'(size);
  assign wr_ok  = is_store && !misalign;
  assign rd_ok  = !is_store && !misalign;

  be_misalign_det #(.OFS_W(OFS_W)) u_det (
    .ofs      (addr_lo),
    .size     (size_e),
    .misalign (misalign)
  );

  be_store_place #(.DATA_W(DATA_W), .LANES(LANES), .OFS_W(OFS_W)) u_st (
    .ofs     (addr_lo),
    .size    (size_e),
    .wr_ok   (wr_ok),
    .st_data (st_data),
    .wdata   (mem_wdata),
    .be      (mem_be)
  );

  be_load_extract #(.DATA_W(DATA_W), .LANES(LANES), .OFS_W(OFS_W)) u_ld (
    .ofs       (addr_lo),
    .size      (size_e),
    .is_signed (is_signed),
    .rd_ok     (rd_ok),
    .mem_rdata (mem_rdata),
    .ld_data   (ld_data)
  );

endmodule

// File: rtl/be_aligner_chk.sv
module be_aligner_chk #(
  parameter int DATA_W = 64,
  parameter int LANES  = DATA_W / 8,
  parameter int OFS_W  = $clog2(LANES)
) (
  input logic [OFS_W-1:0]  addr_lo,
  input logic [1:0]        size,
  input logic              is_signed,
  input logic              is_store,
  input logic [LANES-1:0]  mem_be,
  input logic [DATA_W-1:0] ld_data,
  input logic              misalign
);

  int nbytes;

  always_comb begin
    nbytes = 1 << int'(size);
    // R1: byte accesses never fault
    if (size == 2'b00) begin
      a_r1_byte_ok: assert (!misalign) else $error("byte access flagged misaligned");
    end
    // R3: an aligned store enables exactly its size in lanes
    if (is_store && !misalign) begin
      a_r3_be_count: assert ($countones(mem_be) == nbytes) else $error("enable count wrong");
    end
    // R4: misaligned access is suppressed
    if (misalign) begin
      a_r4_quiet: assert (mem_be == '0 && ld_data == '0) else $error("misaligned access not suppressed");
    end
    // R7: loads write nothing, stores return nothing
    if (!is_store) begin
      a_r7_load_no_be: assert (mem_be == '0) else $error("enable raised on load");
    end else begin
      a_r7_store_no_ld: assert (ld_data == '0) else $error("load data on store");
    end
    // R6: unsigned short loads have clear upper bits
    if (!is_store && !misalign && !is_signed && nbytes < LANES) begin
      a_r6_zero_ext: assert ((ld_data >> (8 * nbytes)) == '0) else $error("zero-extension broken");
    end
  end

endmodule

bind be_aligner be_aligner_chk #(.DATA_W(DATA_W), .LANES(LANES), .OFS_W(OFS_W)) u_chk (
  .addr_lo   (addr_lo),
  .size      (size),
  .is_signed (is_signed),
  .is_store  (is_store),
  .mem_be    (mem_be),
  .ld_data   (ld_data),
  .misalign  (misalign)
);

// File: tb/tb_be_aligner.sv
module tb_be_aligner;

  logic        clk;
  logic        rst_n;
  logic [2:0]  addr_lo;
  logic [1:0]  size;
  logic        is_signed;
  logic        is_store;
  logic [63:0] st_data;
  logic [63:0] mem_rdata;
  logic [63:0] mem_wdata;
  logic [7:0]  mem_be;
  logic [63:0] ld_data;
  logic        misalign;

  int total_chk = 0;
  int bad_chk   = 0;
  int cycles    = 0;
  int seed      = 32'h5eed_1234;

  be_aligner dut (
    .addr_lo   (addr_lo),
    .size      (size),
    .is_signed (is_signed),
    .is_store  (is_store),
    .st_data   (st_data),
    .mem_rdata (mem_rdata),
    .mem_wdata (mem_wdata),
    .mem_be    (mem_be),
    .ld_data   (ld_data),
    .misalign  (misalign)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      bad_chk = bad_chk + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
      $display("  test done: total=%0d bad=%0d", total_chk, bad_chk);
      $finish;
    end
  end

  function automatic bit f_mis(input logic [2:0] a, input logic [1:0] s);
    int n = 1 << int'(s);
    return (int'(a) % n) != 0;
  endfunction

  function automatic logic [63:0] f_wdata(input logic [2:0] a, input logic [1:0] s, input logic [63:0] d);
    logic [63:0] w = '0;
    int n = 1 << int'(s);
    for (int j = 0; j < n; j++) begin
      w[63 - 8*(int'(a) + j) -: 8] = d[8*(n-1-j) +: 8];
    end
    return w;
  endfunction

  function automatic logic [7:0] f_be(input logic [2:0] a, input logic [1:0] s, input logic st);
    logic [7:0] b = '0;
    int n = 1 << int'(s);
    if (st && !f_mis(a, s)) begin
      for (int j = 0; j < n; j++) b[7 - (int'(a) + j)] = 1'b1;
    end
    return b;
  endfunction

  function automatic logic [63:0] f_ld(input logic [2:0] a, input logic [1:0] s, input logic sg,
                                       input logic st, input logic [63:0] m);
    logic [63:0] v = '0;
    int n = 1 << int'(s);
    if (st || f_mis(a, s)) return '0;
    for (int j = 0; j < n; j++) begin
      v[8*(n-1-j) +: 8] = m[63 - 8*(int'(a) + j) -: 8];
    end
    if (sg && n < 8 && v[8*n-1]) begin
      for (int b = 8*n; b < 64; b++) v[b] = 1'b1;
    end
    return v;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total_chk = total_chk + 1;
    if (act !== exp) begin
      bad_chk = bad_chk + 1;
      $display("FAIL %s: actual=%h expected=%h (addr=%0d size=%0d st=%0b sg=%0b)",
               req, act, exp, addr_lo, size, is_store, is_signed);
    end
  endtask

  task automatic apply(input logic [2:0] a, input logic [1:0] s, input logic sg, input logic st,
                       input logic [63:0] d, input logic [63:0] m);
    logic [7:0] eb;
    @(posedge clk);
    addr_lo = a; size = s; is_signed = sg; is_store = st; st_data = d; mem_rdata = m;
    @(negedge clk);
    eb = f_be(a, s, st);
    chk("R1 misalign", {63'd0, misalign}, {63'd0, f_mis(a, s)});
    if (f_mis(a, s))  chk("R4 be zero on misalign", {56'd0, mem_be}, 64'd0);
    else if (!st)     chk("R7 be zero on load", {56'd0, mem_be}, 64'd0);
    else              chk("R3 byte enables", {56'd0, mem_be}, {56'd0, eb});
    if (st && !f_mis(a, s)) begin
      logic [63:0] lm = '0;
      for (int i = 0; i < 8; i++) if (eb[i]) lm[8*i +: 8] = 8'hFF;
      chk("R2 lane data", mem_wdata & lm, f_wdata(a, s, d));
    end
    if (f_mis(a, s))  chk("R4 ld zero on misalign", ld_data, 64'd0);
    else if (st)      chk("R7 ld zero on store", ld_data, 64'd0);
    else              chk("R5/R6 load data", ld_data, f_ld(a, s, sg, st, m));
  endtask

  initial begin
    rst_n = 1'b0;
    addr_lo = '0; size = '0; is_signed = 1'b0; is_store = 1'b0; st_data = '0; mem_rdata = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8: idle inputs give quiet outputs
    chk("R8 idle be", {56'd0, mem_be}, 64'd0);
    chk("R8 idle ld", ld_data, 64'd0);

    // Directed corners
    apply(3'd0, 2'b11, 1'b0, 1'b1, 64'h0102030405060708, 64'd0);         // R2 double at 0
    apply(3'd7, 2'b00, 1'b0, 1'b1, 64'h00000000000000AB, 64'd0);         // R3 last lane
    apply(3'd4, 2'b10, 1'b0, 1'b1, 64'hFFFF_FFFF_DEAD_BEEF, 64'd0);      // R2 word upper discarded
    apply(3'd3, 2'b00, 1'b1, 1'b0, 64'd0, 64'h0000_0080_0000_0000);      // R6 signed byte neg
    apply(3'd3, 2'b00, 1'b0, 1'b0, 64'd0, 64'h0000_0080_0000_0000);      // R6 unsigned byte
    apply(3'd6, 2'b01, 1'b1, 1'b0, 64'd0, 64'h0000_0000_0000_8001);      // R6 signed half
    apply(3'd4, 2'b10, 1'b1, 1'b0, 64'd0, 64'h0000_0000_7FFF_FFFF);      // R6 positive word
    apply(3'd0, 2'b11, 1'b1, 1'b0, 64'd0, 64'hF123_4567_89AB_CDEF);      // R5 double
    apply(3'd2, 2'b10, 1'b0, 1'b1, 64'h1111_2222_3333_4444, 64'd0);      // R4 word misaligned
    apply(3'd4, 2'b11, 1'b1, 1'b0, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF);      // R4 double misaligned
    apply(3'd5, 2'b01, 1'b0, 1'b1, 64'h0000_0000_0000_5A5A, 64'd0);      // R1 half odd

    // Seeded random accesses
    void'($urandom(seed));
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] a;
      logic [1:0] s;
      s = 2'($urandom_range(0, 3));
      a = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 9) < 7) a = a & ~3'((1 << int'(s)) - 1);
      apply(a, s, 1'($urandom), 1'($urandom), {$urandom, $urandom}, {$urandom, $urandom});
    end

    $display("  test done: total=%0d bad=%0d", total_chk, bad_chk);
    $finish;
  end

endmodule